// File: doc/BRIEF.md
# DMA Physical Address Generator

This block turns the programmed state of one DMA transfer into a stream of physical memory addresses, one per data beat. Each channel owns two 8-bit page registers, a low page and a high page, which a host loads through a small port window in which the port offset selects the channel through an irregular map. A transfer is armed with a start pulse that carries the channel, its mode byte, a 16-bit starting offset and a base count. Each beat pulse then yields one registered 31-bit address made of seven bits of the high page, the full low page and the moving 16-bit offset.

The offset walks upward or downward from the starting value according to bit 5 of the mode byte. The programmed transfer length is the base count plus one, scaled by the controller shift (0 for an 8-bit controller, 1 for a 16-bit one). A sequencer with three states, IDLE, RUN and DONE, counts accepted beats. The transitions are: IDLE to RUN on start; RUN to RUN on start (reload) or on a beat that is not the last; RUN to DONE on the beat that brings the position to the length; DONE to RUN on start. Beats in IDLE or DONE are ignored.

Top module: `dma_phys_addr_gen`

## Requirements
- R1: The page port offset `pg_port` selects a channel as 7 to channel 0, 3 to channel 1, 1 to channel 2 and 2 to channel 3; `pg_hi`=0 addresses the channel's low page register and `pg_hi`=1 its high page register, each an independent 8-bit register that reads back on `pg_rdata` the value last written.
- R2: Offsets 0, 4, 5 and 6 map to no channel: a write there changes no page register and a read there returns 0.
- R3: Every address equals {high page bits [6:0], low page [7:0], offset [15:0]} of the active channel, 31 bits; bit 7 of the high page never appears.
- R4: With `xfer_mode` bit 5 = 0, the address of beat n (counting from 0) carries offset (start offset + n) modulo 2^16.
- R5: With `xfer_mode` bit 5 = 1, the address of beat n carries offset (start offset - n) modulo 2^16.
- R6: From the cycle after a start, `xfer_len` equals (base count + 1) shifted left by CTRL_SHIFT.
- R7: `xfer_done` is 0 until the number of accepted beats reaches `xfer_len`, then stays 1; beats in DONE or IDLE leave `phys_addr` unchanged and `addr_valid` low.
- R8: `addr_valid` is high for exactly the cycle after an accepted beat, and `phys_addr` changes only in such a cycle.
- R9: A start in any state clears the beat position, clears `xfer_done` and enters RUN with the new channel, mode, offset and count.
- R10: After reset the sequencer is in IDLE, all page registers read 0, `phys_addr` is 0, and `addr_valid` and `xfer_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pg_wr | input | 1 | Page register write strobe |
| pg_hi | input | 1 | 0 selects the low page, 1 the high page |
| pg_port | input | 3 | Page port offset |
| pg_wdata | input | PAGE_W (8) | Page write data |
| pg_rdata | output | PAGE_W (8) | Page read data for the addressed port |
| xfer_start | input | 1 | Arms a transfer with the fields below |
| xfer_chan | input | 2 | Channel of the transfer |
| xfer_mode | input | 8 | Mode byte; bit 5 selects decrement |
| xfer_base | input | OFS_W (16) | Starting offset |
| xfer_cnt | input | CNT_W (16) | Base count (length minus one, before scaling) |
| beat | input | 1 | Beat advance pulse |
| phys_addr | output | 31 | Registered physical address |
| addr_valid | output | 1 | High the cycle after an accepted beat |
| xfer_len | output | LEN_W (17) | Programmed transfer length |
| xfer_done | output | 1 | Transfer complete |

## Verification
The assertions assume `xfer_start` and `beat` are single-cycle pulses sampled on the rising edge and that the page port is not rewritten for the active channel in the same cycle a beat is taken. The bench drives every input one half cycle away from the rising edge, keeps start and beat to one cycle each, and never overlaps a page write with a beat, so the assertions stay within those assumptions. Sweeps cover every page port in both banks, every channel in both directions with several counts, offset wrap at both ends, a restart mid-transfer and a 16-bit controller instance.

// File: rtl/dma_pag_pkg.sv
package dma_pag_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    // Returns {hit, channel[1:0]} for a page port offset.
    function automatic logic [2:0] chan_of_port(input logic [2:0] port);
        logic [2:0] r;
        case (port)
            3'd7:    r = 3'b1_00;
            3'd3:    r = 3'b1_01;
            3'd1:    r = 3'b1_10;
            3'd2:    r = 3'b1_11;
            default: r = 3'b0_00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dma_page_bank.sv
module dma_page_bank
    import dma_pag_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int PAGE_W = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              hi_sel,
    input  logic [2:0]        port,
    input  logic [PAGE_W-1:0] wdata,
    output logic [PAGE_W-1:0] rdata,
    input  logic [CH_W-1:0]   act_ch,
    output logic [PAGE_W-1:0] act_lo,
    output logic [PAGE_W-1:0] act_hi
);

    logic [NUM_CH-1:0][PAGE_W-1:0] lo_q;
    logic [NUM_CH-1:0][PAGE_W-1:0] hi_q;
    logic [2:0]                    map;
    logic                          hit;
    logic [CH_W-1:0]               sel_ch;
    logic [NUM_CH-1:0]             wr_lo;
    logic [NUM_CH-1:0]             wr_hi;

    assign map    = chan_of_port(port);
    assign hit    = map[2];
    assign sel_ch = CH_W'(map[1:0]);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_we
        assign wr_lo[c] = wr && hit && !hi_sel && (sel_ch == CH_W'(c));
        assign wr_hi[c] = wr && hit &&  hi_sel && (sel_ch == CH_W'(c));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (wr_lo[c]) lo_q[c] <= wdata;
                if (wr_hi[c]) hi_q[c] <= wdata;
            end
        end
    end

    always_comb begin
        if (!hit)        rdata = '0;
        else if (hi_sel) rdata = hi_q[sel_ch];
        else             rdata = lo_q[sel_ch];
    end

    assign act_lo = lo_q[act_ch];
    assign act_hi = hi_q[act_ch];

    // R2: a write to an unmapped port leaves every page register untouched
    a_r2_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !hit) |=> ($stable(lo_q) && $stable(hi_q)));

endmodule

// File: rtl/dma_beat_seq.sv
module dma_beat_seq
    import dma_pag_pkg::*;
#(
    parameter int LEN_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             beat,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] pos,
    output logic             take,
    output logic             done
);

    seq_state_e      state_q, state_d;
    logic [LEN_W-1:0] pos_q, pos_d;
    logic             last;

    assign take = beat && !start && (state_q == ST_RUN);
    assign last = ((pos_q + LEN_W'(1)) == len);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        if (start) begin
            state_d = ST_RUN;
            pos_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RUN: begin
                    if (beat) begin
                        pos_d = pos_q + LEN_W'(1);
                        if (last) state_d = ST_DONE;
                    end
                end
                ST_DONE: state_d = ST_DONE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign pos  = pos_q;
    assign done = (state_q == ST_DONE);

    // R7: the position never passes the programmed length
    a_r7_pos_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (pos_q <= len));

    // R7: completion holds until the next start
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R9: a start always lands in RUN at position zero
    a_r9_start_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ((state_q == ST_RUN) && (pos_q == '0)));

endmodule

// File: rtl/dma_addr_form.sv
module dma_addr_form #(
    parameter int PAGE_W = 8,
    parameter int OFS_W  = 16,
    parameter int LEN_W  = 17,
    localparam int ADDR_W = 2 * PAGE_W - 1 + OFS_W
) (
    input  logic [OFS_W-1:0]  base,
    input  logic [LEN_W-1:0]  pos,
    input  logic              dec,
    input  logic [PAGE_W-1:0] lo,
    input  logic [PAGE_W-1:0] hi,
    output logic [ADDR_W-1:0] addr
);

    logic [OFS_W-1:0] step;
    logic [OFS_W-1:0] ofs;

    assign step = OFS_W'(pos);

    always_comb begin
        if (dec) ofs = base - step;
        else     ofs = base + step;
    end

    assign addr = {hi[PAGE_W-2:0], lo, ofs};

endmodule

// File: rtl/dma_phys_addr_gen.sv
module dma_phys_addr_gen
    import dma_pag_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int PAGE_W     = 8,
    parameter int OFS_W      = 16,
    parameter int CNT_W      = 16,
    parameter int MODE_W     = 8,
    parameter int DIR_BIT    = 5,
    parameter int CTRL_SHIFT = 0,
    localparam int CH_W      = $clog2(NUM_CH),
    localparam int LEN_W     = CNT_W + 1 + CTRL_SHIFT,
    localparam int ADDR_W    = 2 * PAGE_W - 1 + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pg_wr,
    input  logic              pg_hi,
    input  logic [2:0]        pg_port,
    input  logic [PAGE_W-1:0] pg_wdata,
    output logic [PAGE_W-1:0] pg_rdata,
    input  logic              xfer_start,
    input  logic [CH_W-1:0]   xfer_chan,
    input  logic [MODE_W-1:0] xfer_mode,
    input  logic [OFS_W-1:0]  xfer_base,
    input  logic [CNT_W-1:0]  xfer_cnt,
    input  logic              beat,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              addr_valid,
    output logic [LEN_W-1:0]  xfer_len,
    output logic              xfer_done
);

    logic [CH_W-1:0]   cur_ch;
    logic              cur_dec;
    logic [OFS_W-1:0]  cur_base;
    logic [CNT_W-1:0]  cur_cnt;
    logic [PAGE_W-1:0] act_lo, act_hi;
    logic [LEN_W-1:0]  len_w, pos_w;
    logic              take;
    logic [ADDR_W-1:0] addr_d, addr_q;
    logic              valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ch   <= '0;
            cur_dec  <= 1'b0;
            cur_base <= '0;
            cur_cnt  <= '0;
        end else if (xfer_start) begin
            cur_ch   <= xfer_chan;
            cur_dec  <= xfer_mode[DIR_BIT];
            cur_base <= xfer_base;
            cur_cnt  <= xfer_cnt;
        end
    end

    assign len_w = (LEN_W'(cur_cnt) + LEN_W'(1)) << CTRL_SHIFT;

    dma_page_bank #(.NUM_CH(NUM_CH), .PAGE_W(PAGE_W)) u_pages (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (pg_wr),
        .hi_sel (pg_hi),
        .port   (pg_port),
        .wdata  (pg_wdata),
        .rdata  (pg_rdata),
        .act_ch (cur_ch),
        .act_lo (act_lo),
        .act_hi (act_hi)
    );

    dma_beat_seq #(.LEN_W(LEN_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (xfer_start),
        .beat  (beat),
        .len   (len_w),
        .pos   (pos_w),
        .take  (take),
        .done  (xfer_done)
    );

    dma_addr_form #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .LEN_W(LEN_W)) u_form (
        .base (cur_base),
        .pos  (pos_w),
        .dec  (cur_dec),
        .lo   (act_lo),
        .hi   (act_hi),
        .addr (addr_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= take;
            if (take) addr_q <= addr_d;
        end
    end

    assign phys_addr  = addr_q;
    assign addr_valid = valid_q;
    assign xfer_len   = len_w;

    // R8: a valid address only follows a beat pulse
    a_r8_valid_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> $past(beat));

    // R8: the address only moves in a valid cycle
    a_r8_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phys_addr) |-> addr_valid);

    // R7: no address is issued once the transfer is complete
    a_r7_no_beat_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !xfer_start) |=> !addr_valid);

endmodule

// File: tb/sim_dma_phys_addr_gen.sv
`timescale 1ns/1ps
module sim_dma_phys_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pg_wr = 1'b0, pg_hi = 1'b0;
    logic [2:0]  pg_port = '0;
    logic [7:0]  pg_wdata = '0;
    logic [7:0]  pg_rdata, pg_rdata1;
    logic        xfer_start = 1'b0;
    logic [1:0]  xfer_chan = '0;
    logic [7:0]  xfer_mode = '0;
    logic [15:0] xfer_base = '0, xfer_cnt = '0;
    logic        beat = 1'b0;
    logic [30:0] phys_addr, phys_addr1;
    logic        addr_valid, addr_valid1;
    logic [16:0] xfer_len;
    logic [17:0] xfer_len1;
    logic        xfer_done, xfer_done1;

    int tests = 0, fails = 0;
    bit finished = 1'b0;
    logic [7:0] m_lo [4];
    logic [7:0] m_hi [4];

    always #2.5 clk = ~clk;

    dma_phys_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .pg_wr(pg_wr), .pg_hi(pg_hi), .pg_port(pg_port),
        .pg_wdata(pg_wdata), .pg_rdata(pg_rdata), .xfer_start(xfer_start),
        .xfer_chan(xfer_chan), .xfer_mode(xfer_mode), .xfer_base(xfer_base),
        .xfer_cnt(xfer_cnt), .beat(beat), .phys_addr(phys_addr),
        .addr_valid(addr_valid), .xfer_len(xfer_len), .xfer_done(xfer_done)
    );

    dma_phys_addr_gen #(.CTRL_SHIFT(1)) u1 (
        .clk(clk), .rst_n(rst_n), .pg_wr(pg_wr), .pg_hi(pg_hi), .pg_port(pg_port),
        .pg_wdata(pg_wdata), .pg_rdata(pg_rdata1), .xfer_start(xfer_start),
        .xfer_chan(xfer_chan), .xfer_mode(xfer_mode), .xfer_base(xfer_base),
        .xfer_cnt(xfer_cnt), .beat(beat), .phys_addr(phys_addr1),
        .addr_valid(addr_valid1), .xfer_len(xfer_len1), .xfer_done(xfer_done1)
    );

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    function automatic int port_chan(input int p);
        case (p)
            7: return 0;
            3: return 1;
            1: return 2;
            2: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic logic [30:0] exp_addr(input int ch, input logic [15:0] base, input int n, input bit dec);
        logic [15:0] o;
        o = dec ? base - 16'(n) : base + 16'(n);
        return {m_hi[ch][6:0], m_lo[ch], o};
    endfunction

    task automatic pg_write(input bit hi, input int p, input logic [7:0] d);
        @(negedge clk);
        pg_wr = 1'b1; pg_hi = hi; pg_port = 3'(p); pg_wdata = d;
        @(negedge clk);
        pg_wr = 1'b0;
    endtask

    task automatic start_xfer(input int ch, input bit dec, input logic [15:0] base, input logic [15:0] cnt);
        @(negedge clk);
        xfer_start = 1'b1; xfer_chan = 2'(ch);
        xfer_mode = dec ? 8'h20 : 8'h5F & ~8'h20; xfer_base = base; xfer_cnt = cnt;
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    task automatic do_beat;
        @(negedge clk);
        beat = 1'b1;
        @(negedge clk);
        beat = 1'b0;
    endtask

    task automatic run_xfer(input int ch, input bit dec, input logic [15:0] base, input int cnt);
        logic [30:0] held;
        start_xfer(ch, dec, base, 16'(cnt));
        chk("R6", "length", 32'(xfer_len), 32'(cnt + 1));
        chk("R9", "done after start", 32'(xfer_done), 0);
        for (int n = 0; n <= cnt; n++) begin
            do_beat();
            chk("R8", "valid after beat", 32'(addr_valid), 1);
            chk(dec ? "R5" : "R4", "beat address", 32'(phys_addr), 32'(exp_addr(ch, base, n, dec)));
            chk("R7", "done timing", 32'(xfer_done), (n == cnt) ? 1 : 0);
        end
        @(negedge clk);
        chk("R8", "valid one cycle", 32'(addr_valid), 0);
        held = phys_addr;
        do_beat();
        chk("R7", "beat in DONE valid", 32'(addr_valid), 0);
        chk("R7", "beat in DONE addr", 32'(phys_addr), 32'(held));
        chk("R7", "done sticky", 32'(xfer_done), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "valid", 32'(addr_valid), 0);
        chk("R10", "done", 32'(xfer_done), 0);
        chk("R10", "addr", 32'(phys_addr), 0);
        rst_n = 1'b1;
        for (int p = 0; p < 8; p++) begin
            for (int h = 0; h < 2; h++) begin
                @(negedge clk); pg_port = 3'(p); pg_hi = h[0];
                #0.5 chk("R10", "page after reset", 32'(pg_rdata), 0);
            end
        end
        // R7/R10: beat in IDLE does nothing
        do_beat();
        chk("R7", "beat in IDLE valid", 32'(addr_valid), 0);
        chk("R7", "beat in IDLE addr", 32'(phys_addr), 0);

        // R1/R2: write every port in both banks, bit 7 set in high pages
        for (int i = 0; i < 4; i++) begin m_lo[i] = 8'h00; m_hi[i] = 8'h00; end
        for (int p = 0; p < 8; p++) begin
            pg_write(1'b0, p, 8'h30 + 8'(p * 17));
            pg_write(1'b1, p, 8'h80 + 8'(p * 9));
            if (port_chan(p) >= 0) begin
                m_lo[port_chan(p)] = 8'h30 + 8'(p * 17);
                m_hi[port_chan(p)] = 8'h80 + 8'(p * 9);
            end
        end
        for (int p = 0; p < 8; p++) begin
            for (int h = 0; h < 2; h++) begin
                logic [7:0] e;
                @(negedge clk); pg_port = 3'(p); pg_hi = h[0];
                if (port_chan(p) < 0) e = 8'h00;
                else e = h ? m_hi[port_chan(p)] : m_lo[port_chan(p)];
                #0.5 chk(port_chan(p) < 0 ? "R2" : "R1", "page readback", 32'(pg_rdata), 32'(e));
            end
        end

        // R3/R4/R5/R6/R7/R8: every channel, both directions, several counts
        for (int ch = 0; ch < 4; ch++)
            for (int d = 0; d < 2; d++)
                for (int c = 0; c < 3; c++)
                    run_xfer(ch, d[0], 16'h4000 + 16'(ch * 256 + c * 16), c);

        // R4/R5: offset wrap at both ends
        run_xfer(1, 1'b0, 16'hFFFE, 3);
        run_xfer(2, 1'b1, 16'h0001, 3);

        // R3: high page bit 7 excluded, checked on a changed page value
        pg_write(1'b1, 3, 8'hFF);
        m_hi[1] = 8'hFF;
        start_xfer(1, 1'b0, 16'h0010, 0);
        do_beat();
        chk("R3", "hi bit7 dropped", 32'(phys_addr), 32'({7'h7F, m_lo[1], 16'h0010}));

        // R9: restart mid-transfer
        start_xfer(0, 1'b0, 16'h1000, 5);
        do_beat(); do_beat();
        start_xfer(3, 1'b1, 16'h2000, 1);
        chk("R9", "length after restart", 32'(xfer_len), 2);
        chk("R9", "done after restart", 32'(xfer_done), 0);
        do_beat();
        chk("R9", "first beat after restart", 32'(phys_addr), 32'(exp_addr(3, 16'h2000, 0, 1'b1)));
        do_beat();
        chk("R9", "done after restart len", 32'(xfer_done), 1);

        // R6: 16-bit controller doubles the length
        start_xfer(0, 1'b0, 16'h0100, 2);
        chk("R6", "scaled length", 32'(xfer_len1), 6);
        for (int n = 0; n < 6; n++) begin
            do_beat();
            chk("R6", "scaled done timing", 32'(xfer_done1), (n == 5) ? 1 : 0);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule